// File: doc/BRIEF.md
# Wide-Operand Hash Accelerator Bus Wrapper

This block sits between a 32-bit processor bus and a hashing engine whose message input and digest output are each 256 bits wide. The processor fills a message buffer one 32-bit word at a time. Per-byte write enables allow partial stores. The processor then starts the engine through a separate control and status register, polls that register until the engine reports completion, and reads the captured digest back as eight 32-bit words. The hash function itself is not part of this block. It connects through a start pulse, a completion pulse and two 256-bit vectors.

The data port covers sixteen word offsets. Offsets 0 to 7 hold the message, which can be read and written. Offsets 8 to 15 hold the result, which is read-only. In both halves, word 0 carries the most significant 32 bits of the 256-bit vector. The control and status port is a single register. Polling it never touches the operand storage.

Both read ports are registered. A read strobe sampled at one clock edge makes the word available on the read-data output after that edge. The output then holds until the next read.

Top module: `wide_hash_wrap`

## Requirements
- R1: After synchronous reset, the status register, every message word, every result word and the engine start output are all zero.
- R2: A data-port write at offset 0 to 7 updates only the bytes whose byte-enable bit is set. Bit k of the enable selects bits 8k+7..8k of the word. A read at the same offset returns the merged word.
- R3: Message word i drives bits 255-32i down to 224-32i of the engine message output, so word 0 is the most significant word.
- R4: A control write with bit 0 set while the block is idle raises the engine start output for exactly one cycle after the write edge, and sets busy (status bit 0).
- R5: A start request while busy is ignored, and no further engine start pulse is produced.
- R6: Message writes while busy is set are ignored.
- R7: When the engine signals completion while busy, busy clears, done (status bit 1) sets, and the digest is captured. Result word i, at offset 8+i, holds digest bits 255-32i down to 224-32i.
- R8: Done is sticky. A control write with bit 1 set clears it, but a completion in the same cycle leaves it set. An accepted start also clears it.
- R9: Data-port writes at offsets 8 to 15 have no effect.
- R10: Reads return a full 32-bit word, and status bits 31 to 2 always read as zero.
- R11: An engine completion pulse while not busy changes neither the status nor the result buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dp_addr | input | 4 | Data-port word offset (0-7 message, 8-15 result) |
| dp_wr | input | 1 | Data-port write strobe |
| dp_rd | input | 1 | Data-port read strobe |
| dp_be | input | 4 | Data-port byte enables |
| dp_wdata | input | 32 | Data-port write data |
| dp_rdata | output | 32 | Data-port read data, registered |
| cs_wr | input | 1 | Control write strobe (bit 0 start, bit 1 clear done) |
| cs_rd | input | 1 | Status read strobe |
| cs_wdata | input | 32 | Control write data |
| cs_rdata | output | 32 | Status read data (bit 0 busy, bit 1 done), registered |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_msg | output | 256 | Message vector presented to the engine |
| eng_done | input | 1 | Engine completion pulse |
| eng_digest | input | 256 | Digest from the engine, valid with eng_done |

## Verification
The hardest situation to reach is a clear-done write that lands in the same cycle as the engine's completion pulse, because the window is one clock wide and the processor cannot see it. The bench owns the fixed-latency engine stub, so it watches the stub's completion output at the falling edge and drives the clear write into exactly that cycle. It also injects a stray completion pulse while the block is idle. Random message contents and random byte-enable patterns are checked against a byte-merge model held in the bench.

// File: rtl/hash_wrap_pkg.sv
package hash_wrap_pkg;
  localparam int CTL_START_BIT = 0;
  localparam int CTL_CLEAR_BIT = 1;
  localparam int ST_BUSY_BIT   = 0;
  localparam int ST_DONE_BIT   = 1;

  typedef enum logic [0:0] {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/hw_msg_buf.sv
module hw_msg_buf #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 8,
  localparam int BYTES  = WORD_W / 8,
  localparam int IDXW   = $clog2(N_WORDS),
  localparam int FLAT_W = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [BYTES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [FLAT_W-1:0] flat
);
  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      always_ff @(posedge clk) begin
        if (rst) begin
          words[w][8*b +: 8] <= '0;
        end else if (wr_en && !lock && wr_idx == IDXW'(w) && wr_be[b]) begin
          words[w][8*b +: 8] <= wr_data[8*b +: 8];
        end
      end
    end
    assign flat[(N_WORDS-1-w)*WORD_W +: WORD_W] = words[w];
  end

  assign rd_word = words[rd_idx];

  AST_MSG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(flat)); // R6
endmodule

// File: rtl/hw_res_buf.sv
module hw_res_buf #(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 8,
  localparam int IDXW   = $clog2(N_WORDS),
  localparam int FLAT_W = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [FLAT_W-1:0] din,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] words [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[w] <= '0;
      end else if (cap) begin
        words[w] <= din[(N_WORDS-1-w)*WORD_W +: WORD_W];
      end
    end
  end

  assign rd_word = words[rd_idx];
endmodule

// File: rtl/hw_ctrl.sv
module hw_ctrl
  import hash_wrap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic clr_req,
  input  logic eng_done,
  output logic busy,
  output logic done,
  output logic eng_start,
  output logic cap
);
  phase_e phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      done      <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      if (phase == PH_IDLE) begin
        if (start_req) begin
          phase     <= PH_RUN;
          eng_start <= 1'b1;
          done      <= 1'b0;
        end else if (clr_req) begin
          done <= 1'b0;
        end
      end else begin
        if (eng_done) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end else if (clr_req) begin
          done <= 1'b0;
        end
      end
    end
  end

  assign busy = (phase == PH_RUN);
  assign cap  = busy && eng_done;

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start); // R4
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_req) |=> (busy && eng_start)); // R4
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done && !eng_start) |=> !eng_start); // R5
  AST_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done) |=> (!busy && done)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !clr_req && !(start_req && !busy)) |=> done); // R8
endmodule

// File: rtl/wide_hash_wrap.sv
module wide_hash_wrap
  import hash_wrap_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int N_WORDS = 8,
  localparam int BYTES  = WORD_W / 8,
  localparam int IDXW   = $clog2(N_WORDS),
  localparam int AW     = IDXW + 1,
  localparam int FLAT_W = WORD_W * N_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     dp_addr,
  input  logic              dp_wr,
  input  logic              dp_rd,
  input  logic [BYTES-1:0]  dp_be,
  input  logic [WORD_W-1:0] dp_wdata,
  output logic [WORD_W-1:0] dp_rdata,
  input  logic              cs_wr,
  input  logic              cs_rd,
  input  logic [WORD_W-1:0] cs_wdata,
  output logic [WORD_W-1:0] cs_rdata,
  output logic              eng_start,
  output logic [FLAT_W-1:0] eng_msg,
  input  logic              eng_done,
  input  logic [FLAT_W-1:0] eng_digest
);
  logic              busy, done, cap;
  logic              sel_res;
  logic [IDXW-1:0]   idx;
  logic [WORD_W-1:0] msg_word, res_word;

  assign sel_res = dp_addr[AW-1];
  assign idx     = dp_addr[IDXW-1:0];

  hw_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_req (cs_wr && cs_wdata[CTL_START_BIT]),
    .clr_req   (cs_wr && cs_wdata[CTL_CLEAR_BIT]),
    .eng_done  (eng_done),
    .busy      (busy),
    .done      (done),
    .eng_start (eng_start),
    .cap       (cap)
  );

  hw_msg_buf #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_msg (
    .clk     (clk),
    .rst     (rst),
    .lock    (busy),
    .wr_en   (dp_wr && !sel_res),
    .wr_idx  (idx),
    .wr_be   (dp_be),
    .wr_data (dp_wdata),
    .rd_idx  (idx),
    .rd_word (msg_word),
    .flat    (eng_msg)
  );

  hw_res_buf #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_res (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .din     (eng_digest),
    .rd_idx  (idx),
    .rd_word (res_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_rdata <= '0;
    end else if (dp_rd) begin
      dp_rdata <= sel_res ? res_word : msg_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_rdata <= '0;
    end else if (cs_rd) begin
      cs_rdata              <= '0;
      cs_rdata[ST_BUSY_BIT] <= busy;
      cs_rdata[ST_DONE_BIT] <= done;
    end
  end

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    cs_rd |=> (cs_rdata[WORD_W-1:2] == '0)); // R10
  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!busy && eng_done && !cs_wr) |=> (!busy && $stable(done))); // R11
endmodule

// File: tb/wide_hash_wrap_tb.sv
module wide_hash_wrap_tb;
  localparam int LAT = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   dp_addr = '0;
  logic         dp_wr = 1'b0, dp_rd = 1'b0;
  logic [3:0]   dp_be = '0;
  logic [31:0]  dp_wdata = '0, cs_wdata = '0;
  logic         cs_wr = 1'b0, cs_rd = 1'b0;
  logic [31:0]  dp_rdata, cs_rdata;
  logic         eng_start, eng_done;
  logic [255:0] eng_msg, eng_digest;

  logic [255:0] stub_msg = '0;
  logic [7:0]   stub_cnt = '0;
  logic         spur = 1'b0;
  int           launches = 0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0] mmsg [8];
  logic [31:0] mres [8];

  always #5 clk = ~clk;

  wide_hash_wrap u_dut (
    .clk(clk), .rst(rst),
    .dp_addr(dp_addr), .dp_wr(dp_wr), .dp_rd(dp_rd), .dp_be(dp_be),
    .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .cs_wr(cs_wr), .cs_rd(cs_rd), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata),
    .eng_start(eng_start), .eng_msg(eng_msg),
    .eng_done(eng_done), .eng_digest(eng_digest)
  );

  function automatic logic [255:0] dig(input logic [255:0] m);
    return {m[127:0], m[255:128]} ^ {8{32'h5A3C_96E1}};
  endfunction

  function automatic logic [255:0] pack_model();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[255-32*i -: 32] = mmsg[i];
    return v;
  endfunction

  // fixed-latency engine stub
  always_ff @(posedge clk) begin
    if (eng_start) begin
      stub_cnt <= 8'(LAT);
      stub_msg <= eng_msg;
      launches <= launches + 1;
    end else if (stub_cnt != 0) begin
      stub_cnt <= stub_cnt - 1;
    end
  end
  assign eng_done   = (stub_cnt == 8'd1) || spur;
  assign eng_digest = dig(stub_msg);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic dp_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    dp_addr = a; dp_wdata = d; dp_be = be; dp_wr = 1'b1;
    @(negedge clk);
    dp_wr = 1'b0;
  endtask

  task automatic dp_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    dp_addr = a; dp_rd = 1'b1;
    @(negedge clk);
    dp_rd = 1'b0;
    d = dp_rdata;
  endtask

  task automatic cs_write(input logic [31:0] d);
    @(negedge clk);
    cs_wdata = d; cs_wr = 1'b1;
    @(negedge clk);
    cs_wr = 1'b0;
  endtask

  task automatic cs_read(output logic [31:0] d);
    @(negedge clk);
    cs_rd = 1'b1;
    @(negedge clk);
    cs_rd = 1'b0;
    d = cs_rdata;
  endtask

  task automatic model_write(input int i, input logic [31:0] d, input logic [3:0] be);
    for (int b = 0; b < 4; b++) if (be[b]) mmsg[i][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int k = 0; k < 200; k++) begin
      cs_read(s);
      if (s[1]) break;
    end
  endtask

  task automatic check_results(input string req);
    logic [31:0] r;
    logic [255:0] d;
    d = dig(pack_model());
    for (int i = 0; i < 8; i++) begin
      mres[i] = d[255-32*i -: 32];
      dp_read(4'(8 + i), r);
      chk(req, r, mres[i]);
    end
  endtask

  task automatic check_eng_msg();
    logic [255:0] v;
    v = pack_model();
    for (int i = 0; i < 8; i++) chk("R3 eng_msg word", eng_msg[255-32*i -: 32], v[255-32*i -: 32]);
  endtask

  task automatic fill_random();
    logic [31:0] d;
    logic [3:0] be;
    int i;
    for (int k = 0; k < 24; k++) begin
      i = $urandom_range(0, 7);
      d = $urandom;
      be = 4'($urandom);
      dp_write(4'(i), d, be);
      model_write(i, d, be);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, s;
    int l0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin mmsg[i] = '0; mres[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 eng_start", {31'd0, eng_start}, 32'd0);
    cs_read(s);
    chk("R1 status", s, 32'd0);
    for (int i = 0; i < 16; i++) begin
      dp_read(4'(i), r);
      chk("R1 word", r, 32'd0);
    end

    // R2 byte-enable merge, directed then random
    dp_write(4'd0, 32'h1122_3344, 4'b1111); model_write(0, 32'h1122_3344, 4'b1111);
    dp_write(4'd0, 32'hAABB_CCDD, 4'b0100); model_write(0, 32'hAABB_CCDD, 4'b0100);
    dp_read(4'd0, r);
    chk("R2 single byte", r, 32'h11BB_3344);
    fill_random();
    for (int i = 0; i < 8; i++) begin
      dp_read(4'(i), r);
      chk("R2 readback", r, mmsg[i]);
    end
    check_eng_msg();

    // R9 result offsets read-only
    for (int i = 8; i < 16; i++) dp_write(4'(i), $urandom, 4'hF);
    for (int i = 8; i < 16; i++) begin
      dp_read(4'(i), r);
      chk("R9 result write ignored", r, 32'd0);
    end

    // R11 stray completion while idle
    @(negedge clk); spur = 1'b1;
    @(negedge clk); spur = 1'b0;
    cs_read(s);
    chk("R11 status", s, 32'd0);
    dp_read(4'd8, r);
    chk("R11 result", r, 32'd0);

    // R4 start
    l0 = launches;
    cs_write(32'h1);
    chk("R4 start pulse", {31'd0, eng_start}, 32'd1);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'd0, eng_start}, 32'd0);
    cs_read(s);
    chk("R4 busy", s, 32'h1);
    // R6 / R5 while busy
    dp_write(4'd3, 32'hDEAD_BEEF, 4'hF);
    cs_write(32'h1);
    wait_done();
    cs_read(s);
    chk("R7 status done", s, 32'h2);
    chk("R10 upper zero", {2'b00, s[31:2]}, 32'd0);
    chk("R5 single launch", 32'(launches - l0), 32'd1);
    dp_read(4'd3, r);
    chk("R6 msg locked", r, mmsg[3]);
    check_results("R7 digest");
    cs_read(s);
    chk("R8 done sticky", s, 32'h2);
    cs_write(32'h2);
    cs_read(s);
    chk("R8 clear done", s, 32'h0);

    // random rounds; corner: clear coincides with completion
    for (int rnd = 0; rnd < 3; rnd++) begin
      fill_random();
      check_eng_msg();
      cs_write(32'h1);
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (eng_done) break;
      end
      cs_wdata = 32'h2; cs_wr = 1'b1;
      @(negedge clk);
      cs_wr = 1'b0;
      cs_read(s);
      chk("R8 completion beats clear", s, 32'h2);
      check_results("R7 digest random");
    end

    // R8 start clears done
    cs_write(32'h1);
    cs_read(s);
    chk("R8 start clears done", s, 32'h1);
    wait_done();
    check_results("R7 digest final");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule